// File: doc/BRIEF.md
# Prescaled Timer with Forced Compare

This block is an 8-bit timer with a selectable clock divider and a single compare channel that drives a waveform pin. A free-running divider in the system clock domain gives one-cycle advance pulses. The counter moves on those pulses. In normal and clear-on-match modes, a compare match sets, clears or toggles the pin. In the pulse-width mode, the pin is driven by the match and by the wrap of the counter.

Software reaches the block through a simple word-wide register port. It has one write strobe with an address, and one read address whose data is registered one cycle later. Software can load the counter directly, set the compare value, choose the clock division, the waveform mode and the pin action, and clear the two status flags. It can also issue a force strobe. The force strobe applies the pin action at once, without raising a flag and without disturbing the counter.

Top module: `prescaled_cmp_timer`

## Requirements
- R1: Control bits [2:0] select the tick rate. 0 stops the counter. 1, 2, 3, 4, 5, 6 and 7 advance it once every 1, 8, 32, 64, 128, 256 and 1024 system clocks.
- R2: Address 0 reads and writes the counter. A counter write takes effect on its clock edge and wins over a tick in the same cycle.
- R3: In normal mode (control bits [4:3] = 00), the counter wraps from 255 to 0. The overflow flag (address 3 bit 1, port ovf_flag) is set by the tick that leaves 255.
- R4: In clear-on-match mode (bits [4:3] = 01), a tick with the counter equal to the compare value (address 1) returns the counter to 0. The same tick sets the compare flag (address 3 bit 0, port cmp_flag).
- R5: In non-pulse-width modes, a match acts on the pin according to control bits [6:5]: 00 no change, 01 toggle, 10 drive low, 11 drive high. The pin changes at no other time apart from a force.
- R6: Writing control bit 7 as one in a non-pulse-width mode applies the bits [6:5] action of that same write to the pin on that edge. It sets no flag and leaves the counter unchanged, even in clear-on-match mode.
- R7: Control bit 7 always reads as zero. Flag register bits [7:2] read as zero.
- R8: In pulse-width modes (bit 4 = 1), the force strobe has no effect on the pin.
- R9: A counter write suppresses the compare match on the next tick, so a compare value equal to the written value does not match on that tick.
- R10: Writing a one to a flag bit at address 3 clears that flag. A zero leaves it.
- R11: In pulse-width mode with bits [6:5] = 10, a match drives the pin low and the 255-to-0 wrap drives it high. With 11, the two actions are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 counter, 1 compare, 2 control, 3 flags |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 8 | Registered read data, valid one cycle after rd_addr |
| cmp_pin | output | 1 | Compare waveform pin |
| cmp_flag | output | 1 | Compare match flag |
| ovf_flag | output | 1 | Counter overflow flag |

## Verification
The hardest case to reach is the suppressed match. It needs a counter write that lands exactly on the compare value, followed by a tick that would otherwise match. The bench reaches it by stopping the clock select, loading the counter and compare registers, and then opening the divider for an exact number of ticks. The counter position at every tick is therefore known. The same stop-load-run pattern places wraps and matches on known edges for the pin-action sweep, which covers every action from both pin levels. The divider ratios are measured by reading the counter twice, a whole number of periods apart, so the free-running divider phase cancels out.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam logic [1:0] ADDR_COUNT = 2'd0;
  localparam logic [1:0] ADDR_CMP   = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;
  localparam logic [1:0] ADDR_FLAGS = 2'd3;

  typedef enum logic [1:0] {
    WAVE_NORMAL  = 2'd0,
    WAVE_CTC     = 2'd1,
    WAVE_PWM     = 2'd2,
    WAVE_PWM_ALT = 2'd3
  } wave_e;

  typedef enum logic [1:0] {
    OUT_KEEP   = 2'd0,
    OUT_TOGGLE = 2'd1,
    OUT_CLEAR  = 2'd2,
    OUT_SET    = 2'd3
  } outmode_e;

  typedef struct packed {
    outmode_e    out_mode;
    wave_e       wave;
    logic [2:0]  clk_sel;
  } ctrl_t;

  // log2 of the divide ratio for each clock-select code
  function automatic int ratio_shift(input logic [2:0] sel);
    case (sel)
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction

  function automatic logic apply_out(input outmode_e m, input logic pin);
    case (m)
      OUT_TOGGLE: return ~pin;
      OUT_CLEAR:  return 1'b0;
      OUT_SET:    return 1'b1;
      default:    return pin;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PSC_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] clk_sel,
  output logic       tick
);

  logic [PSC_W-1:0] psc;
  logic [7:0]       tap;

  always_ff @(posedge clk) begin
    if (rst) psc <= '0;
    else     psc <= psc + 1'b1;
  end

  for (genvar i = 0; i < 8; i++) begin : g_tap
    localparam int SH = ratio_shift(3'(i));
    if (i == 0) begin : g_off
      assign tap[i] = 1'b0;
    end else if (SH == 0) begin : g_full
      assign tap[i] = 1'b1;
    end else begin : g_div
      assign tap[i] = &psc[SH-1:0];
    end
  end

  assign tick = tap[clk_sel];

  // R1: a divided rate never gives two ticks in a row
  assert_div_gap_R1: assert property (@(posedge clk) disable iff (rst)
    (tick && clk_sel >= 3'd2) |=> (!tick || clk_sel != $past(clk_sel)));

endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  wave_e            wave,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             match,
  output logic             wrap
);

  logic blk;

  assign match = tick && !cnt_wr && !blk && (cnt == cmp_val);
  assign wrap  = tick && !cnt_wr && (&cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      blk <= 1'b0;
    end else if (cnt_wr) begin
      cnt <= cnt_wdata;
      blk <= 1'b1;
    end else if (tick) begin
      blk <= 1'b0;
      if (wave == WAVE_CTC && match) cnt <= '0;
      else                           cnt <= cnt + 1'b1;
    end
  end

  // R1: without a tick or a write the counter holds
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> $stable(cnt));

  // R2: a write lands regardless of a tick
  assert_write_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt == $past(cnt_wdata)));

  // R3: outside clear-on-match a tick adds one
  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && wave != WAVE_CTC) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R9: the tick after a write never matches
  assert_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> !match);

endmodule

// File: rtl/tmr_wave_unit.sv
module tmr_wave_unit
  import tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  wave_e    wave,
  input  outmode_e out_mode,
  input  logic     match,
  input  logic     wrap,
  input  logic     force_req,
  input  outmode_e force_mode,
  output logic     pin
);

  logic pwm;
  assign pwm = wave[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pin <= 1'b0;
    end else if (force_req) begin
      pin <= apply_out(force_mode, pin);
    end else if (pwm) begin
      if (wrap) begin
        if (out_mode == OUT_CLEAR)    pin <= 1'b1;
        else if (out_mode == OUT_SET) pin <= 1'b0;
      end else if (match) begin
        if (out_mode == OUT_CLEAR)    pin <= 1'b0;
        else if (out_mode == OUT_SET) pin <= 1'b1;
      end
    end else if (match) begin
      pin <= apply_out(out_mode, pin);
    end
  end

  // R5: the pin moves only on a match, a wrap or a force
  assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!force_req && !match && !wrap) |=> $stable(pin));

  // R6: a forced set drives the pin high
  assert_force_set_R6: assert property (@(posedge clk) disable iff (rst)
    (force_req && force_mode == OUT_SET) |=> pin);

  // R6: a forced clear drives the pin low
  assert_force_clr_R6: assert property (@(posedge clk) disable iff (rst)
    (force_req && force_mode == OUT_CLEAR) |=> !pin);

endmodule

// File: rtl/prescaled_cmp_timer.sv
module prescaled_cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PSC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             cmp_pin,
  output logic             cmp_flag,
  output logic             ovf_flag
);

  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] cmp_val;
  logic [CNT_W-1:0] cnt;
  logic             tick, match, wrap;
  logic             cnt_wr, ctrl_wr, flag_wr, force_req;
  ctrl_t            ctrl_new;

  assign ctrl_new  = ctrl_t'(wr_data[CTRL_W-1:0]);
  assign cnt_wr    = wr_en && (wr_addr == ADDR_COUNT);
  assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
  assign flag_wr   = wr_en && (wr_addr == ADDR_FLAGS);
  assign force_req = ctrl_wr && wr_data[CTRL_W] && !ctrl_new.wave[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      cmp_val <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CMP) cmp_val <= wr_data;
      if (ctrl_wr)             ctrl    <= ctrl_new;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (match)                     cmp_flag <= 1'b1;
      else if (flag_wr && wr_data[0]) cmp_flag <= 1'b0;
      if (wrap)                      ovf_flag <= 1'b1;
      else if (flag_wr && wr_data[1]) ovf_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        ADDR_COUNT: rd_data <= cnt;
        ADDR_CMP:   rd_data <= cmp_val;
        ADDR_CTRL:  rd_data <= {{(CNT_W-CTRL_W){1'b0}}, ctrl};
        default:    rd_data <= {{(CNT_W-2){1'b0}}, ovf_flag, cmp_flag};
      endcase
    end
  end

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .clk_sel (ctrl.clk_sel),
    .tick    (tick)
  );

  tmr_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .wave      (ctrl.wave),
    .cmp_val   (cmp_val),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (wr_data),
    .cnt       (cnt),
    .match     (match),
    .wrap      (wrap)
  );

  tmr_wave_unit u_wave (
    .clk        (clk),
    .rst        (rst),
    .wave       (ctrl.wave),
    .out_mode   (ctrl.out_mode),
    .match      (match),
    .wrap       (wrap),
    .force_req  (force_req),
    .force_mode (ctrl_new.out_mode),
    .pin        (cmp_pin)
  );

  // R6: the compare flag rises only after a real match, never after a force
  assert_flag_src_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_flag) |-> $past(match));

  // R7: the force bit reads back as zero
  assert_force_rd0_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_CTRL) |=> (rd_data[CNT_W-1] == 1'b0));

  // R10: a one written to the overflow bit clears it when no wrap competes
  assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && wr_data[1] && !wrap) |=> !ovf_flag);

endmodule

// File: tb/tb_prescaled_cmp_timer.sv
module tb_prescaled_cmp_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       cmp_pin, cmp_flag, ovf_flag;

  int n_chk = 0;
  int n_fail = 0;
  logic [1:0] wv = 2'd0;
  logic [1:0] cm = 2'd0;
  logic       exp_pin = 1'b0;
  logic [7:0] va, vb;

  always #10 clk = ~clk;

  prescaled_cmp_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cmp_pin(cmp_pin),
    .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic setmode(input logic [1:0] w, input logic [1:0] c);
    wv = w; cm = c;
    wr(2'd2, {1'b0, c, w, 3'd0});
  endtask

  task automatic run(input int n);
    wr(2'd2, {1'b0, cm, wv, 3'd1});
    repeat (n - 1) @(negedge clk);
    wr(2'd2, {1'b0, cm, wv, 3'd0});
  endtask

  task automatic force_pin(input logic [1:0] c);
    cm = c;
    wr(2'd2, {1'b1, c, wv, 3'd0});
  endtask

  function automatic int ratio(input int cs);
    case (cs)
      1: return 1;    2: return 8;    3: return 32;  4: return 64;
      5: return 128;  6: return 256;  default: return 1024;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // reset state
    check("reset pin", {7'd0, cmp_pin}, 8'd0);
    check("reset flags", {6'd0, ovf_flag, cmp_flag}, 8'd0);
    rd(2'd0, va); check("reset count R2", va, 8'd0);
    rd(2'd2, va); check("reset ctrl R7", va, 8'd0);

    // R1: divider ratios, measured over whole periods
    setmode(2'd0, 2'd0);
    for (int cs = 1; cs < 8; cs++) begin
      int k;
      k = (cs == 7) ? 2 : ((cs == 1) ? 20 : 4);
      wr(2'd2, {1'b0, cm, wv, 3'(cs)});
      rd(2'd0, va);
      repeat (k * ratio(cs) - 1) @(negedge clk);
      rd(2'd0, vb);
      check($sformatf("R1 ratio cs=%0d", cs), vb - va, 8'(k));
    end
    wr(2'd2, {1'b0, cm, wv, 3'd0});
    rd(2'd0, va);
    repeat (50) @(negedge clk);
    rd(2'd0, vb);
    check("R1 stopped", vb, va);
    wr(2'd3, 8'h03);

    // R2: write wins over a tick in the same cycle
    wr(2'd2, {1'b0, cm, wv, 3'd1});
    wr(2'd0, 8'h40);
    wr(2'd2, {1'b0, cm, wv, 3'd0});
    rd(2'd0, va); check("R2 write over tick", va, 8'h41);

    // R3: wrap and overflow flag; R10 clear
    wr(2'd3, 8'h03);
    wr(2'd1, 8'd10);
    wr(2'd0, 8'd254);
    run(1);
    check("R3 no ovf at 255", {7'd0, ovf_flag}, 8'd0);
    run(1);
    rd(2'd0, va); check("R3 wrap to 0", va, 8'd0);
    check("R3 ovf set", {7'd0, ovf_flag}, 8'd1);
    wr(2'd3, 8'h01);
    check("R10 zero bit keeps ovf", {7'd0, ovf_flag}, 8'd1);
    wr(2'd3, 8'h02);
    check("R10 ovf cleared", {7'd0, ovf_flag}, 8'd0);

    // R5: every pin action from both pin levels
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 2; p++) begin
        setmode(2'd0, 2'd0);
        force_pin(p[0] ? 2'd3 : 2'd2);
        exp_pin = p[0];
        wr(2'd1, 8'd10);
        wr(2'd0, 8'd9);
        setmode(2'd0, 2'(c));
        run(2);
        case (c)
          1: exp_pin = ~exp_pin;
          2: exp_pin = 1'b0;
          3: exp_pin = 1'b1;
          default: ;
        endcase
        check($sformatf("R5 action %0d from %0d", c, p), {7'd0, cmp_pin}, {7'd0, exp_pin});
        check("R4 match flag", {7'd0, cmp_flag}, 8'd1);
        wr(2'd3, 8'h01);
        check("R10 cmp cleared", {7'd0, cmp_flag}, 8'd0);
      end
    end

    // R9 blocking, R4 clear-on-match
    setmode(2'd1, 2'd0);
    wr(2'd1, 8'd5);
    wr(2'd0, 8'd5);
    run(1);
    rd(2'd0, va); check("R9 blocked count", va, 8'd6);
    check("R9 no flag", {7'd0, cmp_flag}, 8'd0);
    wr(2'd0, 8'd4);
    run(1);
    rd(2'd0, va); check("R9 pre-match count", va, 8'd5);
    run(1);
    rd(2'd0, va); check("R4 cleared to 0", va, 8'd0);
    check("R4 flag", {7'd0, cmp_flag}, 8'd1);
    wr(2'd3, 8'h01);

    // R6: force in clear-on-match mode with count equal to compare
    wr(2'd1, 8'd7);
    wr(2'd0, 8'd7);
    force_pin(2'd3); check("R6 force set", {7'd0, cmp_pin}, 8'd1);
    force_pin(2'd2); check("R6 force clear", {7'd0, cmp_pin}, 8'd0);
    force_pin(2'd1); check("R6 force toggle", {7'd0, cmp_pin}, 8'd1);
    force_pin(2'd0); check("R6 force keep", {7'd0, cmp_pin}, 8'd1);
    check("R6 no flag", {7'd0, cmp_flag}, 8'd0);
    rd(2'd0, va); check("R6 count unchanged", va, 8'd7);
    rd(2'd2, va); check("R7 force reads zero", va, {1'b0, cm, wv, 3'd0});
    rd(2'd3, va); check("R7 flag reserved", va & 8'hFC, 8'd0);

    // R11: pulse-width actions
    setmode(2'd0, 2'd0);
    force_pin(2'd3);
    setmode(2'd2, 2'd2);
    wr(2'd1, 8'd100);
    wr(2'd0, 8'd98);
    run(3);
    check("R11 clear mode match low", {7'd0, cmp_pin}, 8'd0);
    wr(2'd0, 8'd254);
    run(2);
    check("R11 clear mode wrap high", {7'd0, cmp_pin}, 8'd1);
    setmode(2'd2, 2'd3);
    wr(2'd0, 8'd254);
    run(2);
    check("R11 set mode wrap low", {7'd0, cmp_pin}, 8'd0);
    wr(2'd0, 8'd98);
    run(3);
    check("R11 set mode match high", {7'd0, cmp_pin}, 8'd1);

    // R8: force ignored in pulse-width mode
    wr(2'd2, {1'b1, 2'd2, 2'd2, 3'd0});
    cm = 2'd2;
    check("R8 force ignored", {7'd0, cmp_pin}, 8'd1);
    rd(2'd0, va); check("R8 count unchanged", va, 8'd101);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule